// File: doc/BRIEF.md
# Private Interrupt Winner Selector

This block looks at a bank of per-processor private interrupts and chooses the one that should be offered to the processor interface next. For each interrupt it receives a pending bit, an enable bit, an active bit, an 8-bit priority and a 2-bit resolved group code. It also receives one enable bit per group. An interrupt takes part in the contest only when it is pending, enabled, not active and its group is switched on. Among the interrupts that take part, the smallest priority value wins. When two of them have the same priority, the lower interrupt number wins. The result (number, priority, group and a valid flag) is registered, so it appears one clock after the inputs that produced it.

Alongside the winner, the block reports one flag per group. Each flag says whether this processor may take part in the choice of a target for a one-of-many interrupt of that group. The processor is excluded while it is asleep, while the group is disabled, or while that group's inhibit bit is set. The block also presents a registered two-bit state for every interrupt, formed from its pending and active bits.

Top module: `irq_winner_sel`

## Requirements
- R1: An interrupt is a candidate only when all four of these hold: its pending bit is 1, its enable bit is 1, its active bit is 0, and the group-enable bit indexed by its group code is 1. Group code 0 is group 0, code 1 is secure group 1 and code 2 is non-secure group 1. These codes index bit 0, bit 1 and bit 2 of the group-enable and inhibit inputs. Code 3 never qualifies.
- R2: Among candidates, the one with the numerically smallest priority value is reported, together with that priority.
- R3: When several candidates share the smallest priority, the one with the lowest interrupt number is reported.
- R4: When there is no candidate, `win_valid_o` is 0, `win_prio_o` is 0xFF, and `win_id_o` and `win_grp_o` are 0.
- R5: `win_grp_o` carries the group code of the reported interrupt.
- R6: `elig_o[g]` is 1 exactly when `low_power_i` is 0, `grp_en_i[g]` is 1 and `inhibit_i[g]` is 0.
- R7: `status_o[2k+1:2k]` for interrupt k is {active, pending}: 00 means inactive, 01 pending, 10 active, and 11 active and pending.
- R8: Every output reflects the inputs sampled at the previous rising clock edge. A change of input is not visible before that edge.
- R9: While reset is held and after it is released, before any input is sampled, the outputs are: valid 0, priority 0xFF, number 0, group 0, eligibility 0 and status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | N_IRQ | Pending bit per interrupt |
| en_i | input | N_IRQ | Enable bit per interrupt |
| act_i | input | N_IRQ | Active bit per interrupt |
| prio_i | input | N_IRQ*PRIO_W | Priority of interrupt k at bits [k*PRIO_W +: PRIO_W] |
| grp_i | input | 2*N_IRQ | Resolved group code of interrupt k at bits [2k +: 2] |
| grp_en_i | input | 3 | Enable per group code 0..2 |
| inhibit_i | input | 3 | One-of-many inhibit per group code 0..2 |
| low_power_i | input | 1 | Processor is asleep |
| win_id_o | output | ID_W | Number of the winning interrupt |
| win_prio_o | output | PRIO_W | Priority of the winner, 0xFF when none |
| win_grp_o | output | 2 | Group code of the winner |
| win_valid_o | output | 1 | A winner exists |
| elig_o | output | 3 | One-of-many eligibility per group code |
| status_o | output | 2*N_IRQ | {active, pending} per interrupt |

## Verification
The hardest case to reach from the ports is a tie at the smallest priority between candidates that are far apart in the comparison tree. In that case the lower number must win across several levels of the tree while nearer, higher-numbered leaves hold the same value. The stimulus reaches it in two ways. It forces all interrupts to one priority and then removes the lowest candidates one by one through the active, enable and group bits. It also runs many random patterns whose priorities come from only four values, so that ties are frequent and spread across the tree.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  localparam int NUM_GRP = 3;

  typedef enum logic [1:0] {
    GRP_G0     = 2'd0,
    GRP_G1_SEC = 2'd1,
    GRP_G1_NS  = 2'd2,
    GRP_RSVD   = 2'd3
  } grp_e;

  // Group code is usable only if it is one of the three real groups and enabled.
  function automatic logic grp_usable(input logic [1:0] code,
                                      input logic [NUM_GRP-1:0] grp_en);
    logic ok;
    ok = 1'b0;
    if (code != GRP_RSVD) ok = grp_en[code];
    return ok;
  endfunction

  // Two-bit lifecycle code: {active, pending}.
  function automatic logic [1:0] life_code(input logic pend, input logic act);
    return {act, pend};
  endfunction

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0]   pend_i,
  input  logic [N_IRQ-1:0]   en_i,
  input  logic [N_IRQ-1:0]   act_i,
  input  logic [2*N_IRQ-1:0] grp_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  output logic [N_IRQ-1:0]   cand_o,
  output logic [2*N_IRQ-1:0] life_o
);

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    assign cand_o[k] = pend_i[k] & en_i[k] & ~act_i[k]
                     & grp_usable(grp_i[2*k +: 2], grp_en_i);
    assign life_o[2*k +: 2] = life_code(pend_i[k], act_i[k]);
  end

endmodule

// File: rtl/irq_cmp_tree.sv
module irq_cmp_tree #(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 8,
  parameter int ID_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic [N_IRQ-1:0]        cand_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [2*N_IRQ-1:0]      grp_i,
  output logic                    best_valid_o,
  output logic [PRIO_W-1:0]       best_prio_o,
  output logic [ID_W-1:0]         best_id_o,
  output logic [1:0]              best_grp_o
);

  localparam int LVL  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam int LEAF = 1 << LVL;

  // Right child wins only if strictly better; equal priority keeps the left (lower ID).
  function automatic logic right_wins(input logic lv, input logic [PRIO_W-1:0] lp,
                                      input logic rv, input logic [PRIO_W-1:0] rp);
    return rv && (!lv || (rp < lp));
  endfunction

  logic              nv [2*LEAF];
  logic [PRIO_W-1:0] np [2*LEAF];
  logic [ID_W-1:0]   ni [2*LEAF];
  logic [1:0]        ng [2*LEAF];

  assign nv[0] = 1'b0;
  assign np[0] = '0;
  assign ni[0] = '0;
  assign ng[0] = '0;

  for (genvar k = 0; k < LEAF; k++) begin : g_leaf
    if (k < N_IRQ) begin : g_real
      assign nv[LEAF+k] = cand_i[k];
      assign np[LEAF+k] = prio_i[k*PRIO_W +: PRIO_W];
      assign ni[LEAF+k] = ID_W'(k);
      assign ng[LEAF+k] = grp_i[2*k +: 2];
    end else begin : g_pad
      assign nv[LEAF+k] = 1'b0;
      assign np[LEAF+k] = '1;
      assign ni[LEAF+k] = '0;
      assign ng[LEAF+k] = '0;
    end
  end

  for (genvar i = 1; i < LEAF; i++) begin : g_node
    logic take_r;
    assign take_r = right_wins(nv[2*i], np[2*i], nv[2*i+1], np[2*i+1]);
    assign nv[i]  = nv[2*i] | nv[2*i+1];
    assign np[i]  = take_r ? np[2*i+1] : np[2*i];
    assign ni[i]  = take_r ? ni[2*i+1] : ni[2*i];
    assign ng[i]  = take_r ? ng[2*i+1] : ng[2*i];
  end

  assign best_valid_o = nv[1];
  assign best_prio_o  = np[1];
  assign best_id_o    = ni[1];
  assign best_grp_o   = ng[1];

endmodule

// File: rtl/irq_eligible.sv
module irq_eligible
  import irq_sel_pkg::*;
(
  input  logic               low_power_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic [NUM_GRP-1:0] inhibit_i,
  output logic [NUM_GRP-1:0] elig_o
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign elig_o[g] = ~low_power_i & grp_en_i[g] & ~inhibit_i[g];
  end

endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel
  import irq_sel_pkg::*;
#(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 8,
  parameter int ID_W   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IRQ-1:0]        pend_i,
  input  logic [N_IRQ-1:0]        en_i,
  input  logic [N_IRQ-1:0]        act_i,
  input  logic [N_IRQ*PRIO_W-1:0] prio_i,
  input  logic [2*N_IRQ-1:0]      grp_i,
  input  logic [2:0]              grp_en_i,
  input  logic [2:0]              inhibit_i,
  input  logic                    low_power_i,
  output logic [ID_W-1:0]         win_id_o,
  output logic [PRIO_W-1:0]       win_prio_o,
  output logic [1:0]              win_grp_o,
  output logic                    win_valid_o,
  output logic [2:0]              elig_o,
  output logic [2*N_IRQ-1:0]      status_o
);

  logic [N_IRQ-1:0]   cand_w;
  logic [2*N_IRQ-1:0] life_w;
  logic               best_valid_w;
  logic [PRIO_W-1:0]  best_prio_w;
  logic [ID_W-1:0]    best_id_w;
  logic [1:0]         best_grp_w;
  logic [2:0]         elig_w;

  irq_qualify #(.N_IRQ(N_IRQ)) u_qual (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .act_i    (act_i),
    .grp_i    (grp_i),
    .grp_en_i (grp_en_i),
    .cand_o   (cand_w),
    .life_o   (life_w)
  );

  irq_cmp_tree #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
    .cand_i       (cand_w),
    .prio_i       (prio_i),
    .grp_i        (grp_i),
    .best_valid_o (best_valid_w),
    .best_prio_o  (best_prio_w),
    .best_id_o    (best_id_w),
    .best_grp_o   (best_grp_w)
  );

  irq_eligible u_elig (
    .low_power_i (low_power_i),
    .grp_en_i    (grp_en_i),
    .inhibit_i   (inhibit_i),
    .elig_o      (elig_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_o <= 1'b0;
      win_prio_o  <= '1;
      win_id_o    <= '0;
      win_grp_o   <= '0;
      elig_o      <= '0;
      status_o    <= '0;
    end else begin
      win_valid_o <= best_valid_w;
      win_prio_o  <= best_valid_w ? best_prio_w : '1;
      win_id_o    <= best_valid_w ? best_id_w : '0;
      win_grp_o   <= best_valid_w ? best_grp_w : '0;
      elig_o      <= elig_w;
      status_o    <= life_w;
    end
  end

endmodule

// File: rtl/irq_winner_sel_chk.sv
module irq_winner_sel_chk #(
  parameter int N_IRQ  = 32,
  parameter int PRIO_W = 8,
  parameter int ID_W   = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_IRQ-1:0]        pend_i,
  input logic [N_IRQ-1:0]        en_i,
  input logic [N_IRQ-1:0]        act_i,
  input logic [N_IRQ*PRIO_W-1:0] prio_i,
  input logic [2*N_IRQ-1:0]      grp_i,
  input logic [2:0]              grp_en_i,
  input logic [2:0]              inhibit_i,
  input logic                    low_power_i,
  input logic [ID_W-1:0]         win_id_o,
  input logic [PRIO_W-1:0]       win_prio_o,
  input logic [1:0]              win_grp_o,
  input logic                    win_valid_o,
  input logic [2:0]              elig_o,
  input logic [2*N_IRQ-1:0]      status_o
);

  logic [N_IRQ-1:0]        p_pend, p_en, p_act;
  logic [N_IRQ*PRIO_W-1:0] p_prio;
  logic [2*N_IRQ-1:0]      p_grp;
  logic [3:0]              p_gen;
  logic [2:0]              p_inh;
  logic                    p_lp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_pend <= '0; p_en <= '0; p_act <= '0;
      p_prio <= '0; p_grp <= '0; p_gen <= '0;
      p_inh  <= '0; p_lp  <= 1'b0;
    end else begin
      p_pend <= pend_i; p_en <= en_i; p_act <= act_i;
      p_prio <= prio_i; p_grp <= grp_i; p_gen <= {1'b0, grp_en_i};
      p_inh  <= inhibit_i; p_lp <= low_power_i;
    end
  end

  logic [PRIO_W-1:0] sel_prio;
  logic [1:0]        sel_grp;
  assign sel_prio = PRIO_W'(p_prio >> (int'(win_id_o) * PRIO_W));
  assign sel_grp  = 2'(p_grp >> (int'(win_id_o) * 2));

  // R1
  win_is_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (p_pend[win_id_o] && p_en[win_id_o] && !p_act[win_id_o] && p_gen[win_grp_o]));

  // R2
  win_prio_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (sel_prio == win_prio_o));

  // R5
  win_grp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (sel_grp == win_grp_o));

  // R4
  idle_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> (win_prio_o == '1 && win_id_o == '0 && win_grp_o == 2'd0));

  // R6
  sleep_blocks_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_lp |-> (elig_o == 3'b000));

  // R6
  inhibit_blocks_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_o & (p_inh | ~p_gen[2:0])) == 3'b000);

  // R7
  for (genvar k = 0; k < N_IRQ; k++) begin : g_life
    life_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[2*k +: 2] == {p_act[k], p_pend[k]});
  end

endmodule

bind irq_winner_sel irq_winner_sel_chk #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i), .act_i(act_i),
  .prio_i(prio_i), .grp_i(grp_i), .grp_en_i(grp_en_i), .inhibit_i(inhibit_i),
  .low_power_i(low_power_i), .win_id_o(win_id_o), .win_prio_o(win_prio_o),
  .win_grp_o(win_grp_o), .win_valid_o(win_valid_o), .elig_o(elig_o), .status_o(status_o)
);

// File: tb/tb_irq_winner_sel.sv
module tb_irq_winner_sel;

  localparam int N  = 32;
  localparam int PW = 8;
  localparam int IW = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pend = '0, en = '0, act = '0;
  logic [N*PW-1:0] prio = '0;
  logic [2*N-1:0] grp = '0;
  logic [2:0]     gen = '0, inh = '0;
  logic           lp = 1'b0;

  logic [IW-1:0]  win_id;
  logic [PW-1:0]  win_prio;
  logic [1:0]     win_grp;
  logic           win_valid;
  logic [2:0]     elig;
  logic [2*N-1:0] status;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_winner_sel #(.N_IRQ(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .act_i(act),
    .prio_i(prio), .grp_i(grp), .grp_en_i(gen), .inhibit_i(inh),
    .low_power_i(lp), .win_id_o(win_id), .win_prio_o(win_prio),
    .win_grp_o(win_grp), .win_valid_o(win_valid), .elig_o(elig), .status_o(status)
  );

  task automatic check(input string req, input string what, input longint act_v, input longint exp_v);
    nchk++;
    if (act_v != exp_v) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  // Independent reference: linear scan, replace only on strictly smaller priority.
  task automatic expect_all(input string req);
    int best = -1;
    int bp = 256;
    logic [2:0] ex_el;
    for (int k = 0; k < N; k++) begin
      int g = int'(grp[2*k +: 2]);
      int p = int'(prio[k*PW +: PW]);
      bit q = pend[k] && en[k] && !act[k] && (g != 3) && gen[g];
      if (q && p < bp) begin best = k; bp = p; end
    end
    for (int g = 0; g < 3; g++) ex_el[g] = !lp && gen[g] && !inh[g];
    check(req, "valid", win_valid, best >= 0);
    check(req, "prio", win_prio, best >= 0 ? bp : 255);
    check(req, "id", win_id, best >= 0 ? best : 0);
    check(req, "grp", win_grp, best >= 0 ? int'(grp[2*best +: 2]) : 0);
    check("R6", "elig", elig, ex_el);
    for (int k = 0; k < N; k++)
      check("R7", $sformatf("status[%0d]", k), status[2*k +: 2], {act[k], pend[k]});
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state while held
    check("R9", "valid", win_valid, 0);
    check("R9", "prio", win_prio, 255);
    check("R9", "id", win_id, 0);
    check("R9", "elig", elig, 0);
    check("R9", "status", status, 0);
    rst_n = 1'b1;
    #1;
    check("R9", "prio after release", win_prio, 255);

    // R4 nothing pending
    gen = 3'b111;
    settle();
    expect_all("R4");

    // R1 R2 single candidate per interrupt, all group codes
    for (int k = 0; k < N; k++) begin
      pend = '0; en = '1; act = '0;
      pend[k] = 1'b1;
      prio[k*PW +: PW] = PW'(8'hF0 - k);
      grp[2*k +: 2] = 2'(k % 3);
      settle();
      expect_all("R2");
    end

    // R8 latency: new input not visible before the next rising edge
    pend = '0; settle();
    pend[7] = 1'b1; prio[7*PW +: PW] = 8'h10; grp[15:14] = 2'd2;
    #1;
    check("R8", "valid before edge", win_valid, 0);
    settle();
    check("R8", "valid after edge", win_valid, 1);
    check("R8", "id after edge", win_id, 7);

    // R3 all tied: remove lowest candidates one at a time by different means
    prio = '0; grp = '0; pend = '1; en = '1; act = '0;
    for (int k = 0; k < N; k++) prio[k*PW +: PW] = 8'h40;
    for (int k = 0; k < N; k++) begin
      settle();
      expect_all("R3");
      check("R3", "tie id", win_id, k);
      case (k % 3)
        0: act[k] = 1'b1;
        1: en[k] = 1'b0;
        default: grp[2*k +: 2] = 2'd3;
      endcase
    end
    settle();
    expect_all("R4");

    // R1 disabled group hides a better candidate; R5 group reported
    pend = '0; en = '1; act = '0; grp = '0;
    pend[3] = 1; prio[3*PW +: PW] = 8'h01; grp[7:6] = 2'd1;
    pend[20] = 1; prio[20*PW +: PW] = 8'h80; grp[41:40] = 2'd2;
    gen = 3'b101;
    settle();
    expect_all("R1");
    check("R5", "grp of winner", win_grp, 2);
    gen = 3'b111;
    settle();
    check("R5", "grp of winner", win_grp, 1);
    check("R1", "id", win_id, 3);

    // R6 exhaustive eligibility sweep
    for (int v = 0; v < 128; v++) begin
      lp = v[6]; gen = v[5:3]; inh = v[2:0];
      settle();
      expect_all("R6");
    end
    lp = 0; inh = 0; gen = 3'b111;

    // R2 R3 R5 R7 random patterns with a narrow priority range for frequent ties
    for (int it = 0; it < 300; it++) begin
      pend = {$urandom, $urandom} >> 32;
      en   = $urandom | $urandom;
      act  = $urandom & $urandom;
      grp  = {$urandom, $urandom};
      gen  = 3'($urandom);
      for (int k = 0; k < N; k++) prio[k*PW +: PW] = PW'($urandom_range(0, 3) * 8 + (it % 2) * 250 / 2);
      settle();
      expect_all("R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule